// File: doc/BRIEF.md
# Interprocessor Interrupt Control Register

This block is the host-side control and status register for interrupts sent from a second processor. A remote-memory server raises a one-cycle strobe when a remote interrupt packet arrives. The strobe sets a pending flag. While the flag is set, the block requests an interrupt on the priority level that host software has assigned. The host issues commands on a simple command port. A conditions-out command assigns the level and can clear the flag. A conditions-in command reads back the flag and the level. The data-in and data-out commands do nothing useful: data-in reads zero and data-out is discarded.

The block does not decode device numbers and does not arbitrate between priority levels. Both tasks belong to the surrounding bus logic. Every response and the request vector come from registers.

Top module: `ipi_ctrl_reg`

## Requirements
- R1: A conditions-out command (`cmd_op` = 0) loads the priority level from `cmd_wdata[2:0]`. Bits above bit 3 have no effect.
- R2: In a conditions-out command, `cmd_wdata[3]` = 1 clears the pending flag. `cmd_wdata[3]` = 0 leaves the flag unchanged.
- R3: A conditions-in command (`cmd_op` = 1) pulses `rsp_valid` for one cycle, one clock edge later. `rsp_rdata` then carries the pending flag in bit 3 and the level in bits 2:0, and every other bit is zero.
- R4: A cycle with `remote_strobe` high sets the pending flag.
- R5: `irq_req` is one-hot or zero. While the flag is set and the level L is nonzero, only bit L-1 is set. The vector changes on the same clock edge as the state that drives it.
- R6: When the level is 0, no request is raised, even if the flag is set.
- R7: If a strobe and a clearing conditions-out command arrive in the same cycle, the flag ends up set.
- R8: A data-in command (`cmd_op` = 3) answers with `rsp_valid` and an all-zero `rsp_rdata`. A data-out command (`cmd_op` = 2) changes neither the level nor the flag.
- R9: A synchronous active-high reset clears the level, the flag, `irq_req` and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command: 0 cond-out, 1 cond-in, 2 data-out, 3 data-in |
| cmd_wdata | input | DATA_W | Write data for cond-out and data-out |
| remote_strobe | input | 1 | Remote interrupt arrival, one cycle per event |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DATA_W | Read response data |
| irq_req | output | 7 | One-hot request; bit i stands for level i+1 |

## Verification
If the flag or the level is held wrong, it shows on `irq_req` at the clock edge after the event that caused it. It also shows in the next conditions-in response, one edge after that command. A lost strobe, a clear that fails to take effect, or a clear that wins over a strobe leaves the request vector wrong from that edge on. A data-out command that leaks into the level moves the request bit to another position.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    OP_COND_OUT = 2'd0,
    OP_COND_IN  = 2'd1,
    OP_DATA_OUT = 2'd2,
    OP_DATA_IN  = 2'd3
  } ipi_op_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode #(
  parameter int PRI_W = 3
) (
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [PRI_W:0]   ctl_bits,
  output logic             load_pri,
  output logic [PRI_W-1:0] pri_val,
  output logic             clr_req,
  output logic             rd_status,
  output logic             rd_zero
);
  import ipi_pkg::*;
  ipi_op_e op;
  always_comb begin
    op        = ipi_op_e'(cmd_op);
    load_pri  = cmd_valid && (op == OP_COND_OUT);
    pri_val   = ctl_bits[PRI_W-1:0];
    clr_req   = load_pri && ctl_bits[PRI_W];
    rd_status = cmd_valid && (op == OP_COND_IN);
    rd_zero   = cmd_valid && (op == OP_DATA_IN);
  end
endmodule

// File: rtl/ipi_level_router.sv
module ipi_level_router #(
  parameter int PRI_W  = 3,
  parameter int LEVELS = (1 << PRI_W) - 1
) (
  input  logic              pend,
  input  logic [PRI_W-1:0]  level,
  output logic [LEVELS-1:0] req
);
  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    assign req[i] = pend && (level == PRI_W'(i + 1));
  end
endmodule

// File: rtl/ipi_state_reg.sv
module ipi_state_reg #(
  parameter int PRI_W  = 3,
  parameter int LEVELS = (1 << PRI_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_pri,
  input  logic [PRI_W-1:0]  pri_val,
  input  logic              clr_req,
  input  logic              set_req,
  output logic              pend_q,
  output logic [PRI_W-1:0]  pri_q,
  output logic [LEVELS-1:0] irq_q
);
  logic              pend_n;
  logic [PRI_W-1:0]  pri_n;
  logic [LEVELS-1:0] irq_n;

  always_comb begin
    pri_n  = load_pri ? pri_val : pri_q;
    pend_n = set_req || (pend_q && !clr_req);
  end

  ipi_level_router #(.PRI_W(PRI_W), .LEVELS(LEVELS)) u_router (
    .pend (pend_n),
    .level(pri_n),
    .req  (irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      pri_q  <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= pend_n;
      pri_q  <= pri_n;
      irq_q  <= irq_n;
    end
  end
endmodule

// File: rtl/ipi_read_port.sv
module ipi_read_port #(
  parameter int DATA_W = 36,
  parameter int PRI_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_status,
  input  logic              rd_zero,
  input  logic              pend_q,
  input  logic [PRI_W-1:0]  pri_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int STAT_W = PRI_W + 1;
  logic [STAT_W-1:0] status;
  assign status = {pend_q, pri_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_status || rd_zero;
      rsp_rdata <= rd_status ? {{(DATA_W-STAT_W){1'b0}}, status} : '0;
    end
  end
endmodule

// File: rtl/ipi_ctrl_reg.sv
module ipi_ctrl_reg #(
  parameter int DATA_W = 36,
  parameter int PRI_W  = 3,
  localparam int LEVELS = (1 << PRI_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              remote_strobe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [LEVELS-1:0] irq_req
);
  logic             load_pri, clr_req, rd_status, rd_zero;
  logic [PRI_W-1:0] pri_val;
  logic             pend_q;
  logic [PRI_W-1:0] pri_q;

  ipi_cmd_decode #(.PRI_W(PRI_W)) u_dec (
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .ctl_bits (cmd_wdata[PRI_W:0]),
    .load_pri (load_pri),
    .pri_val  (pri_val),
    .clr_req  (clr_req),
    .rd_status(rd_status),
    .rd_zero  (rd_zero)
  );

  ipi_state_reg #(.PRI_W(PRI_W), .LEVELS(LEVELS)) u_state (
    .clk     (clk),
    .rst     (rst),
    .load_pri(load_pri),
    .pri_val (pri_val),
    .clr_req (clr_req),
    .set_req (remote_strobe),
    .pend_q  (pend_q),
    .pri_q   (pri_q),
    .irq_q   (irq_req)
  );

  ipi_read_port #(.DATA_W(DATA_W), .PRI_W(PRI_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_status(rd_status),
    .rd_zero  (rd_zero),
    .pend_q   (pend_q),
    .pri_q    (pri_q),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/ipi_ctrl_reg_sva.sv
module ipi_ctrl_reg_sva #(
  parameter int DATA_W = 36,
  parameter int PRI_W  = 3,
  parameter int LEVELS = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              remote_strobe,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [LEVELS-1:0] irq_req,
  input logic              pend_q,
  input logic [PRI_W-1:0]  pri_q
);
  assert_level_load_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0) |=> (pri_q == $past(cmd_wdata[PRI_W-1:0])));
  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0 && cmd_wdata[PRI_W] && !remote_strobe) |=> !pend_q);
  assert_strobe_sets_R4: assert property (@(posedge clk) disable iff (rst)
    remote_strobe |=> pend_q);
  assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_req));
  assert_level0_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (pri_q == '0) |-> (irq_req == '0));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (remote_strobe && cmd_valid && cmd_op == 2'd0 && cmd_wdata[PRI_W]) |=> pend_q);
  assert_datain_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3) |=> (rsp_valid && rsp_rdata == '0));
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!pend_q && pri_q == '0 && irq_req == '0 && !rsp_valid));
endmodule

bind ipi_ctrl_reg ipi_ctrl_reg_sva #(.DATA_W(DATA_W), .PRI_W(PRI_W), .LEVELS(LEVELS)) u_sva (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_wdata(cmd_wdata), .remote_strobe(remote_strobe),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_req(irq_req),
  .pend_q(pend_q), .pri_q(pri_q)
);

// File: tb/ipi_ctrl_reg_tb.sv
`timescale 1ns/1ps
module ipi_ctrl_reg_tb;
  localparam int DW = 36;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          remote_strobe = 1'b0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [6:0]    irq_req;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipi_ctrl_reg u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .remote_strobe(remote_strobe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_req(irq_req)
  );

  function automatic logic [6:0] exp_irq(input int lvl, input bit pend);
    if (!pend || lvl == 0) return 7'd0;
    return 7'(1 << (lvl - 1));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit v, input logic [1:0] op, input logic [DW-1:0] d, input bit stb);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_wdata = d; remote_strobe = stb;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_wdata = '0; remote_strobe = 1'b0;
  endtask

  task automatic read_stat(input string req, input logic [DW-1:0] exp);
    issue(1'b1, 2'd1, '0, 1'b0);
    chk(req, {63'd0, rsp_valid}, 64'd1);
    chk(req, 64'(rsp_rdata), 64'(exp));
    @(negedge clk);
    chk(req, {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9", {57'd0, irq_req}, 64'd0);
    chk("R9", {63'd0, rsp_valid}, 64'd0);
    read_stat("R9", '0);

    for (int p = 0; p < 8; p++) begin
      issue(1'b1, 2'd0, DW'(p) | DW'(8), 1'b0);
      read_stat("R1", DW'(p));
      chk("R1", {57'd0, irq_req}, 64'd0);
      issue(1'b0, 2'd0, '0, 1'b1);
      chk("R5", {57'd0, irq_req}, {57'd0, exp_irq(p, 1)});
      if (p == 0) chk("R6", {57'd0, irq_req}, 64'd0);
      read_stat("R3", DW'(8 + p));
      issue(1'b1, 2'd3, '0, 1'b0);
      chk("R8", {63'd0, rsp_valid}, 64'd1);
      chk("R8", 64'(rsp_rdata), 64'd0);
      issue(1'b1, 2'd2, {DW{1'b1}}, 1'b0);
      chk("R8", {57'd0, irq_req}, {57'd0, exp_irq(p, 1)});
      read_stat("R8", DW'(8 + p));
      issue(1'b1, 2'd0, DW'((p + 1) % 8), 1'b0);
      chk("R2", {57'd0, irq_req}, {57'd0, exp_irq((p + 1) % 8, 1)});
      read_stat("R2", DW'(8 + (p + 1) % 8));
      issue(1'b1, 2'd0, DW'(8 + p), 1'b0);
      chk("R2", {57'd0, irq_req}, 64'd0);
      read_stat("R2", DW'(p));
    end

    issue(1'b1, 2'd0, {{(DW-4){1'b1}}, 4'b0101}, 1'b0);
    read_stat("R1", DW'(5));
    issue(1'b1, 2'd0, DW'(8 + 5), 1'b1);
    chk("R7", {57'd0, irq_req}, {57'd0, exp_irq(5, 1)});
    read_stat("R7", DW'(13));
    issue(1'b1, 2'd1, '0, 1'b1);
    chk("R4", 64'(rsp_rdata), 64'd13);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9", {57'd0, irq_req}, 64'd0);
    read_stat("R9", '0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule